// File: doc/BRIEF.md
# Serial-Loaded PRG Bank Mapper

This block produces the upper program-memory address lines for an 8-bit CPU cartridge bus. Its four 5-bit bank registers are not written in parallel. A write anywhere in $8000-$FFFF passes CPU data bit 0 into a shift register, least significant bit first. The fifth such write moves the assembled value into the register that CPU A14:A13 select. A write with data bit 7 set aborts a partial load.

From the register contents and the live CPU address, the block drives ROM address bits A18..A14, a PRG RAM bank number, and a RAM chip enable for the $6000-$7FFF window. It also drives the two CHR bank values. Board wiring enters in two ways. Parameters fix the ROM size, the RAM size and whether CHR memory is RAM; in that case, spare CHR bank bits supply ROM A18 and the RAM bank. A static variant input covers the other wiring. Code 3 makes the RAM-disable bit inert. Code 5 passes CPU A14 straight to ROM A14. Every other code behaves like code 0.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, the mode field selects the last-bank-fixed mode, all bank registers are 0 and the shifter is empty. With the default parameters, reads at $C000 give A18..A14 = 01111 and reads at $8000 give 00000.
- R2: Each write with cpu_addr[15]=1 and data bit 7=0 shifts data bit 0 in, LSB first. On the fifth such write, the 5-bit value goes to a register chosen by cpu_addr[14:13]: 00 control, 01 CHR bank 0, 10 CHR bank 1, 11 PRG bank. The shifter then empties. Writes with cpu_addr[15]=0 do not touch the shifter.
- R3: A write with cpu_addr[15]=1 and data bit 7=1 empties the shifter and sets control bits [3:2] to 11. The other control bits and all other registers keep their values.
- R4: Control bits [3:2] set the mapping of PRG bank bits [3:0] onto A17..A14. With 00 or 01, a 32 KiB bank is used: A17..A15 = PRG[3:1] and A14 = CPU A14. With 10, $8000-$BFFF maps to bank 0 and $C000-$FFFF maps to PRG[3:0]. With 11, $8000-$BFFF maps to PRG[3:0] and $C000-$FFFF maps to bank 15.
- R5: With CHR RAM, a 512 KiB ROM and 32 KiB of RAM (the defaults), A18 equals CHR bank 0 bit 4 and the RAM bank equals CHR bank 0 bits [3:2].
- R6: ram_ce is 1 only when cpu_addr is in $6000-$7FFF, RAM is present, and the effective disable bit is 0. Outside variant 3, the disable bit is PRG bank bit 4.
- R7: With variant 3, PRG bank bit 4 has no effect on ram_ce.
- R8: With variant 5, ROM A14 equals CPU A14 in every mode, so PRG bank bit 0 has no effect. A18..A15 are unchanged from the normal mapping.
- R9: Variant codes 1, 2 and 4, and every code other than 3 and 5, give the same outputs as code 0.
- R10: chr_bank0 and chr_bank1 always show the current CHR bank register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes are committed on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle write strobe |
| variant | input | 4 | Static board-variant code |
| rom_hi | output | 5 | PRG ROM address bits A18..A14 |
| ram_bank | output | 2 | PRG RAM 8 KiB bank select |
| ram_ce | output | 1 | PRG RAM chip enable |
| chr_bank0 | output | 5 | CHR bank register 0 |
| chr_bank1 | output | 5 | CHR bank register 1 |

## Verification
The assertions assume that cpu_wr is a single-cycle strobe sampled on the rising edge. They also assume that variant is static while the outputs are judged, and that cpu_addr is stable in each cycle, since the outputs are combinational in it. The bench drives every input on the falling edge and holds each write for exactly one cycle. It changes variant only between reads, and it treats each read as a fresh combinational lookup. Random writes mix partial loads, bit-7 aborts and writes below $8000. A bench model of the shifter predicts every register, so the checks follow the load sequence through each interruption.

// File: rtl/prg_bank_mapper.sv
`timescale 1ns/1ps
module prg_bank_mapper #(
  parameter int ROM_KB  = 512,
  parameter int RAM_KB  = 32,
  parameter bit CHR_RAM = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic [3:0]  variant,
  output logic [4:0]  rom_hi,
  output logic [1:0]  ram_bank,
  output logic        ram_ce,
  output logic [4:0]  chr_bank0,
  output logic [4:0]  chr_bank1
);
  localparam int ROM_BITS = (ROM_KB >= 32) ? $clog2(ROM_KB / 16) : 1;
  localparam int RAM_BITS = (RAM_KB > 8) ? $clog2(RAM_KB / 8) : 0;
  localparam logic [4:0] ROM_MASK = 5'((32'd1 << ROM_BITS) - 1);

  logic [4:0] sr, ctrl, chr0, chr1, prg;
  logic [2:0] cnt;

  wire        wr_hit = cpu_wr && cpu_addr[15];
  wire [4:0]  full   = {cpu_data[0], sr[4:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      cnt  <= '0;
      ctrl <= 5'b01100;
      chr0 <= '0;
      chr1 <= '0;
      prg  <= '0;
    end else if (wr_hit) begin
      if (cpu_data[7]) begin
        sr        <= '0;
        cnt       <= '0;
        ctrl[3:2] <= 2'b11;
      end else if (cnt == 3'd4) begin
        sr  <= '0;
        cnt <= '0;
        case (cpu_addr[14:13])
          2'b00:   ctrl <= full;
          2'b01:   chr0 <= full;
          2'b10:   chr1 <= full;
          default: prg  <= full;
        endcase
      end else begin
        sr  <= full;
        cnt <= cnt + 3'd1;
      end
    end
  end

  wire       v_keep_ram = (variant == 4'd3);
  wire       v_cpu_a14  = (variant == 4'd5);
  wire       a14        = cpu_addr[14];
  wire [1:0] mode       = ctrl[3:2];

  logic [3:0] lo;
  always_comb begin
    case (mode)
      2'b10:   lo = a14 ? prg[3:0] : 4'h0;
      2'b11:   lo = a14 ? 4'hF : prg[3:0];
      default: lo = {prg[3:1], a14};
    endcase
    if (v_cpu_a14) lo[0] = a14;
  end

  wire a18 = (CHR_RAM && ROM_BITS == 5) ? chr0[4] : 1'b0;
  assign rom_hi = {a18, lo} & ROM_MASK;

  generate
    if (CHR_RAM && RAM_BITS >= 2) begin : g_rb2
      assign ram_bank = chr0[3:2];
    end else if (CHR_RAM && RAM_BITS == 1) begin : g_rb1
      assign ram_bank = {1'b0, chr0[3]};
    end else begin : g_rb0
      assign ram_bank = 2'b00;
    end
  endgenerate

  wire ram_off = v_keep_ram ? 1'b0 : prg[4];
  assign ram_ce    = (RAM_KB > 0) && (cpu_addr[15:13] == 3'b011) && !ram_off;
  assign chr_bank0 = chr0;
  assign chr_bank1 = chr1;

  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_data[7]) |=> (ctrl[3:2] == 2'b11 && cnt == 3'd0));
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd4);
  p_low_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cpu_wr && cpu_addr[15])) |=> $stable(cnt) && $stable(prg) && $stable(ctrl));
  p_ram_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (cpu_addr[15:13] == 3'b011));
  p_keep_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 4'd3 && cpu_addr[15:13] == 3'b011 && RAM_KB > 0) |-> ram_ce);
  p_cpu_a14_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 4'd5) |-> (rom_hi[0] == cpu_addr[14]));
  p_fix_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && a14) |-> (rom_hi[3:0] == 4'hF));
endmodule

// File: tb/test_prg_bank_mapper.sv
`timescale 1ns/1ps
module test_prg_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [3:0]  variant = 4'd0;
  logic [4:0]  rom_hi, chr_bank0, chr_bank1;
  logic [1:0]  ram_bank;
  logic        ram_ce;

  int total = 0, bad = 0;
  bit done = 0;

  logic [4:0] m_sr, m_ctrl, m_chr0, m_chr1, m_prg;
  int m_cnt;

  always #2.5 clk = ~clk;

  prg_bank_mapper i_prg_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .variant(variant), .rom_hi(rom_hi), .ram_bank(ram_bank),
    .ram_ce(ram_ce), .chr_bank0(chr_bank0), .chr_bank1(chr_bank1));

  function automatic logic [4:0] exp_rom(logic a14, logic [3:0] v);
    logic [3:0] lo;
    case (m_ctrl[3:2])
      2'b10:   lo = a14 ? m_prg[3:0] : 4'h0;
      2'b11:   lo = a14 ? 4'hF : m_prg[3:0];
      default: lo = {m_prg[3:1], a14};
    endcase
    if (v == 4'd5) lo[0] = a14;
    return {m_chr0[4], lo};
  endfunction

  function automatic logic exp_ce(logic [15:0] a, logic [3:0] v);
    return (a[15:13] == 3'b011) && (v == 4'd3 || !m_prg[4]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a[15]) begin
      if (d[7]) begin
        m_sr = 0; m_cnt = 0; m_ctrl[3:2] = 2'b11;
      end else if (m_cnt == 4) begin
        case (a[14:13])
          2'b00: m_ctrl = {d[0], m_sr[4:1]};
          2'b01: m_chr0 = {d[0], m_sr[4:1]};
          2'b10: m_chr1 = {d[0], m_sr[4:1]};
          default: m_prg = {d[0], m_sr[4:1]};
        endcase
        m_sr = 0; m_cnt = 0;
      end else begin
        m_sr = {d[0], m_sr[4:1]}; m_cnt++;
      end
    end
  endtask

  task automatic load(logic [1:0] sel, logic [4:0] val);
    for (int i = 0; i < 5; i++) wr({1'b1, sel, 13'h0155}, {7'h2a, val[i]});
  endtask

  task automatic probe(string req, logic [15:0] a, logic [3:0] v);
    cpu_addr = a; variant = v;
    #1;
    check(req, rom_hi, exp_rom(a[14], v));
    check(req, ram_ce, exp_ce(a, v));
    check("R5", ram_bank, m_chr0[3:2]);
    check("R10", {chr_bank1, chr_bank0}, {m_chr1, m_chr0});
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] r0, r1;
    void'($urandom(32'd4242));
    m_sr = 0; m_cnt = 0; m_ctrl = 5'b01100; m_chr0 = 0; m_chr1 = 0; m_prg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cpu_addr = 16'hC000; #1; check("R1", rom_hi, 5'b01111);
    cpu_addr = 16'h8000; #1; check("R1", rom_hi, 5'b00000);
    cpu_addr = 16'h6000; #1; check("R1", ram_ce, 1'b1);

    load(2'b11, 5'b00101);
    probe("R2", 16'h8000, 0); check("R2", rom_hi, 5'b00101);
    load(2'b01, 5'b11000);
    probe("R5", 16'hC123, 0); check("R5", rom_hi[4], 1'b1); check("R5", ram_bank, 2'b10);
    load(2'b10, 5'b10110); probe("R10", 16'h8000, 0);

    wr(16'h8000, 8'h01); wr(16'h8000, 8'h01);
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h00);
    wr(16'hE000, 8'h00); wr(16'hE000, 8'h00); wr(16'hE000, 8'h00);
    probe("R2", 16'h8000, 0); check("R2", m_prg, 5'b00011);

    load(2'b00, 5'b00000);
    probe("R4", 16'h8000, 0); probe("R4", 16'hC000, 0);
    load(2'b00, 5'b01000);
    probe("R4", 16'h8000, 0); probe("R4", 16'hC000, 0); check("R4", rom_hi[3:0], 4'h3);
    wr(16'hA000, 8'h01); wr(16'hA000, 8'h01); wr(16'h8000, 8'h80);
    probe("R3", 16'hC000, 0); check("R3", rom_hi[3:0], 4'hF);
    load(2'b11, 5'b10000);
    probe("R6", 16'h6000, 0); check("R6", ram_ce, 1'b0);
    probe("R7", 16'h7FFF, 3); check("R7", ram_ce, 1'b1);
    probe("R6", 16'h5FFF, 3); check("R6", ram_ce, 1'b0);
    load(2'b11, 5'b00111);
    probe("R8", 16'h8000, 5); check("R8", rom_hi[0], 1'b0);
    probe("R8", 16'hC000, 5);

    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) wr({1'b1, 15'($urandom)}, 8'h80 | 8'($urandom));
      else if (k == 1) wr(16'h6000 | 16'($urandom_range(0, 16'h1fff)), 8'($urandom));
      else if (k < 5) load(2'($urandom), 5'($urandom));
      else wr({1'b1, 15'($urandom)}, 8'($urandom) & 8'h7f);
      for (int j = 0; j < 3; j++) begin
        logic [15:0] a = 16'($urandom);
        logic [3:0] v = 4'($urandom);
        probe("R4", a, v);
        cpu_addr = a; variant = v; #1; r0 = rom_hi; r1 = {4'b0, ram_ce};
        if (v != 3 && v != 5) begin
          variant = 4'd0; #1;
          check("R9", {rom_hi, ram_ce}, {r0, r1[0]});
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule